// File: doc/BRIEF.md
# Banked Stack and Link Register Switcher

This block holds the working stack pointer, link register and saved-status word of a processor core. Behind them sit six private shadow banks, one per processor mode. When the core asks to enter a new mode, the block parks the live values in the shadow bank of the mode being left. It then loads the live registers from the shadow bank of the mode being entered. Because of this, each mode sees its own stack pointer and return address, and every mode except user sees its own saved-status word.

The core reads the live registers on three always-valid read ports. It updates them through three write-enable/data pairs. A mode change is requested with a one-cycle strobe and a 5-bit mode code. The whole park-and-load swap completes on one clock edge. A request naming the current mode is skipped. A request carrying a code that names no mode is refused and raises an error pulse.

Top module: `bank_switcher`

## Requirements
- R1: While reset is high at a clock edge, the mode becomes supervisor (10011), the bank index becomes 3, all three read ports and every shadow slot become zero, and the error output becomes 0.
- R2: The mode codes and bank indices are: user 10000 → 0, FIQ 10001 → 1, IRQ 10010 → 2, supervisor 10011 → 3, abort 10111 → 4, undefined 11011 → 5. The bank index output always matches the current mode.
- R3: A request with a valid code that differs from the current mode sets the current mode and bank index to the target one cycle after the request edge.
- R4: On a valid switch, the live stack pointer and link register are stored in the outgoing mode's shadow bank. They are then replaced by the values held in the target's bank, so a later return to that mode restores them.
- R5: For every mode except user, the saved-status word is stored on leaving the mode and reloaded on entering it.
- R6: User mode has no saved-status slot. Entering user mode leaves the live saved-status word unchanged, and leaving user mode overwrites no other mode's saved-status slot.
- R7: A request whose code equals the current mode changes nothing: mode, bank index and all three read ports keep their values.
- R8: A request with any other code, including 00000, moves no register and keeps the mode. It drives the error output high for exactly the cycle after the request edge.
- R9: A register write in the same cycle as a valid switch is applied before the save, so the written value goes into the outgoing mode's shadow bank.
- R10: Without a switch, a write-enable pulse puts its data on the matching read port from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_wr_en | input | 1 | Write enable for the live stack pointer |
| sp_wr_data | input | DATA_W | Stack pointer write data |
| lr_wr_en | input | 1 | Write enable for the live link register |
| lr_wr_data | input | DATA_W | Link register write data |
| ps_wr_en | input | 1 | Write enable for the live saved-status word |
| ps_wr_data | input | DATA_W | Saved-status write data |
| sw_req | input | 1 | Mode change request strobe |
| sw_mode | input | 5 | Target mode code |
| sp_rd | output | DATA_W | Live stack pointer |
| lr_rd | output | DATA_W | Live link register |
| ps_rd | output | DATA_W | Live saved-status word |
| cur_mode | output | 5 | Current mode code |
| bank_idx | output | 3 | Current bank index |
| sw_err | output | 1 | Error pulse after a refused request |

## Verification
A first round-trip between supervisor and IRQ with distinct values in each bank shows whether saving and restoring target the right slots. A freshly entered bank must read zero, which separates a real load from a pass-through. Trips through user mode, with saved-status writes made while in user, separate correct handling of the missing slot from an accidental save or load. Repeated requests for the current mode and illegal codes, both alone and combined with writes, show whether skipped requests really leave state alone. A walk through all six modes confirms every code-to-bank mapping.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    localparam int MODE_W    = 5;
    localparam int BANK_CNT  = 6;
    localparam int BANK_W    = $clog2(BANK_CNT);

    typedef logic [MODE_W-1:0] mode_code_t;
    typedef logic [BANK_W-1:0] bank_t;

    localparam mode_code_t CODE_USR = 5'b10000;
    localparam mode_code_t CODE_FIQ = 5'b10001;
    localparam mode_code_t CODE_IRQ = 5'b10010;
    localparam mode_code_t CODE_SVC = 5'b10011;
    localparam mode_code_t CODE_ABT = 5'b10111;
    localparam mode_code_t CODE_UND = 5'b11011;

    localparam bank_t BANK_USR = 3'd0;
    localparam bank_t BANK_FIQ = 3'd1;
    localparam bank_t BANK_IRQ = 3'd2;
    localparam bank_t BANK_SVC = 3'd3;
    localparam bank_t BANK_ABT = 3'd4;
    localparam bank_t BANK_UND = 3'd5;

    typedef struct packed {
        logic  ok;
        bank_t bank;
    } mode_lookup_t;

    function automatic mode_lookup_t lookup_mode(input mode_code_t code);
        mode_lookup_t r;
        r.ok   = 1'b1;
        r.bank = BANK_USR;
        unique case (code)
            CODE_USR: r.bank = BANK_USR;
            CODE_FIQ: r.bank = BANK_FIQ;
            CODE_IRQ: r.bank = BANK_IRQ;
            CODE_SVC: r.bank = BANK_SVC;
            CODE_ABT: r.bank = BANK_ABT;
            CODE_UND: r.bank = BANK_UND;
            default:  r.ok   = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bsw_mode_decoder.sv
module bsw_mode_decoder
    import bsw_pkg::*;
(
    input  mode_code_t code,
    output logic       ok,
    output bank_t      bank
);
    mode_lookup_t res;

    always_comb begin
        res  = lookup_mode(code);
        ok   = res.ok;
        bank = res.bank;
    end
endmodule

// File: rtl/bsw_shadow_bank.sv
module bsw_shadow_bank #(
    parameter int DATA_W = 32,
    parameter bit HAS_PS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save_en,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] lr_in,
    input  logic [DATA_W-1:0] ps_in,
    output logic [DATA_W-1:0] sp_q,
    output logic [DATA_W-1:0] lr_q,
    output logic [DATA_W-1:0] ps_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            lr_q <= '0;
        end else if (save_en) begin
            sp_q <= sp_in;
            lr_q <= lr_in;
        end
    end

    generate
        if (HAS_PS) begin : g_ps
            always_ff @(posedge clk) begin
                if (rst)          ps_q <= '0;
                else if (save_en) ps_q <= ps_in;
            end
        end else begin : g_no_ps
            logic unused_ps;
            assign unused_ps = ^ps_in;
            assign ps_q      = '0;
        end
    endgenerate

    // R4: a bank that is not being saved keeps its contents
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !save_en |=> ($stable(sp_q) && $stable(lr_q)));
endmodule

// File: rtl/bank_switcher.sv
module bank_switcher
    import bsw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sp_wr_en,
    input  logic [DATA_W-1:0] sp_wr_data,
    input  logic              lr_wr_en,
    input  logic [DATA_W-1:0] lr_wr_data,
    input  logic              ps_wr_en,
    input  logic [DATA_W-1:0] ps_wr_data,
    input  logic              sw_req,
    input  logic [4:0]        sw_mode,
    output logic [DATA_W-1:0] sp_rd,
    output logic [DATA_W-1:0] lr_rd,
    output logic [DATA_W-1:0] ps_rd,
    output logic [4:0]        cur_mode,
    output logic [2:0]        bank_idx,
    output logic              sw_err
);
    localparam int NB = BANK_CNT;

    logic [DATA_W-1:0] sp_q, lr_q, ps_q;
    mode_code_t        mode_q;
    bank_t             bank_q;
    logic              err_q;

    logic              tgt_ok;
    bank_t             tgt_bank;
    logic              do_sw;
    logic [DATA_W-1:0] sp_eff, lr_eff, ps_eff;
    logic [DATA_W-1:0] sel_sp, sel_lr, sel_ps;

    logic [DATA_W-1:0] sh_sp [NB];
    logic [DATA_W-1:0] sh_lr [NB];
    logic [DATA_W-1:0] sh_ps [NB];

    bsw_mode_decoder u_dec (
        .code (sw_mode),
        .ok   (tgt_ok),
        .bank (tgt_bank)
    );

    // writes first, so a same-cycle write is what gets parked
    assign sp_eff = sp_wr_en ? sp_wr_data : sp_q;
    assign lr_eff = lr_wr_en ? lr_wr_data : lr_q;
    assign ps_eff = ps_wr_en ? ps_wr_data : ps_q;
    assign do_sw  = sw_req && tgt_ok && (sw_mode != mode_q);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            bsw_shadow_bank #(
                .DATA_W (DATA_W),
                .HAS_PS (b != int'(BANK_USR))
            ) u_bank (
                .clk     (clk),
                .rst     (rst),
                .save_en (do_sw && (bank_q == bank_t'(b))),
                .sp_in   (sp_eff),
                .lr_in   (lr_eff),
                .ps_in   (ps_eff),
                .sp_q    (sh_sp[b]),
                .lr_q    (sh_lr[b]),
                .ps_q    (sh_ps[b])
            );
        end
    endgenerate

    always_comb begin
        sel_sp = '0;
        sel_lr = '0;
        sel_ps = '0;
        for (int b = 0; b < NB; b++) begin
            if (tgt_bank == bank_t'(b)) begin
                sel_sp = sh_sp[b];
                sel_lr = sh_lr[b];
                sel_ps = sh_ps[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= '0;
            lr_q   <= '0;
            ps_q   <= '0;
            mode_q <= CODE_SVC;
            bank_q <= BANK_SVC;
            err_q  <= 1'b0;
        end else begin
            err_q <= sw_req && !tgt_ok;
            if (do_sw) begin
                sp_q   <= sel_sp;
                lr_q   <= sel_lr;
                ps_q   <= (tgt_bank == BANK_USR) ? ps_eff : sel_ps;
                mode_q <= sw_mode;
                bank_q <= tgt_bank;
            end else begin
                sp_q <= sp_eff;
                lr_q <= lr_eff;
                ps_q <= ps_eff;
            end
        end
    end

    assign sp_rd    = sp_q;
    assign lr_rd    = lr_q;
    assign ps_rd    = ps_q;
    assign cur_mode = mode_q;
    assign bank_idx = bank_q;
    assign sw_err   = err_q;

    mode_lookup_t cur_lk;
    assign cur_lk = lookup_mode(mode_q);

    assert_bank_matches_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_lk.ok && (cur_lk.bank == bank_q)));

    assert_switch_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (sw_req && tgt_ok && (sw_mode != cur_mode)) |=> (cur_mode == $past(sw_mode)));

    assert_user_keeps_ps_R6: assert property (@(posedge clk) disable iff (rst)
        (do_sw && (tgt_bank == BANK_USR) && !ps_wr_en) |=> $stable(ps_rd));

    assert_same_mode_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (sw_req && (sw_mode == cur_mode) && !sp_wr_en && !lr_wr_en && !ps_wr_en)
        |=> ($stable(sp_rd) && $stable(lr_rd) && $stable(ps_rd) && $stable(cur_mode)));

    assert_bad_code_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !tgt_ok) |=> (sw_err && $stable(cur_mode) && $stable(bank_idx)));

    assert_err_only_after_bad_R8: assert property (@(posedge clk) disable iff (rst)
        !(sw_req && !tgt_ok) |=> !sw_err);
endmodule

// File: tb/bank_switcher_tb.sv
module bank_switcher_tb_top;
    localparam int DW = 32;
    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sp_wr_en = 0, lr_wr_en = 0, ps_wr_en = 0, sw_req = 0;
    logic [DW-1:0] sp_wr_data = '0, lr_wr_data = '0, ps_wr_data = '0;
    logic [4:0] sw_mode = '0;
    logic [DW-1:0] sp_rd, lr_rd, ps_rd;
    logic [4:0] cur_mode;
    logic [2:0] bank_idx;
    logic sw_err;

    always #4 clk = ~clk;

    bank_switcher #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .lr_wr_en(lr_wr_en), .lr_wr_data(lr_wr_data),
        .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data),
        .sw_req(sw_req), .sw_mode(sw_mode),
        .sp_rd(sp_rd), .lr_rd(lr_rd), .ps_rd(ps_rd),
        .cur_mode(cur_mode), .bank_idx(bank_idx), .sw_err(sw_err)
    );

    typedef struct {
        string         tag;
        logic [DW-1:0] sp, lr, ps;
        logic [4:0]    mode;
        logic [2:0]    bank;
        logic          err;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] m_sp = '0, m_lr = '0, m_ps = '0;
    logic [4:0]    m_mode = M_SVC;
    logic [2:0]    m_bank = 3'd3;
    logic [DW-1:0] s_sp [6];
    logic [DW-1:0] s_lr [6];
    logic [DW-1:0] s_ps [6];

    function automatic bit code_bank(input logic [4:0] c, output logic [2:0] b);
        b = 3'd0;
        case (c)
            M_USR: b = 3'd0;
            M_FIQ: b = 3'd1;
            M_IRQ: b = 3'd2;
            M_SVC: b = 3'd3;
            M_ABT: b = 3'd4;
            M_UND: b = 3'd5;
            default: return 1'b0;
        endcase
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push_model(input string tag, input bit err);
        exp_t e;
        e.tag = tag; e.sp = m_sp; e.lr = m_lr; e.ps = m_ps;
        e.mode = m_mode; e.bank = m_bank; e.err = err;
        exp_q.push_back(e);
    endtask

    task automatic step(input string tag, input bit req, input logic [4:0] code,
                        input bit wsp, input logic [DW-1:0] dsp,
                        input bit wlr, input logic [DW-1:0] dlr,
                        input bit wps, input logic [DW-1:0] dps);
        logic [DW-1:0] e_sp, e_lr, e_ps;
        logic [2:0] b;
        bit ok;
        @(negedge clk);
        sw_req = req; sw_mode = code;
        sp_wr_en = wsp; sp_wr_data = dsp;
        lr_wr_en = wlr; lr_wr_data = dlr;
        ps_wr_en = wps; ps_wr_data = dps;
        e_sp = wsp ? dsp : m_sp;
        e_lr = wlr ? dlr : m_lr;
        e_ps = wps ? dps : m_ps;
        ok = code_bank(code, b);
        if (req && ok && code != m_mode) begin
            s_sp[m_bank] = e_sp;
            s_lr[m_bank] = e_lr;
            if (m_bank != 3'd0) s_ps[m_bank] = e_ps;
            m_sp = s_sp[b];
            m_lr = s_lr[b];
            m_ps = (b != 3'd0) ? s_ps[b] : e_ps;
            m_mode = code;
            m_bank = b;
        end else begin
            m_sp = e_sp; m_lr = e_lr; m_ps = e_ps;
        end
        @(posedge clk);
        #1;
        push_model(tag, req && !ok);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, M_USR, 0, '0, 0, '0, 0, '0);
    endtask

    task automatic go(input string tag, input logic [4:0] code);
        step(tag, 1, code, 0, '0, 0, '0, 0, '0);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: compares registered outputs half a cycle after each edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "sp", sp_rd, e.sp);
                chk(e.tag, "lr", lr_rd, e.lr);
                chk(e.tag, "ps", ps_rd, e.ps);
                chk(e.tag, "mode", DW'(cur_mode), DW'(e.mode));
                chk(e.tag, "bank", DW'(bank_idx), DW'(e.bank));
                chk(e.tag, "err", DW'(sw_err), DW'(e.err));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            s_sp[i] = '0; s_lr[i] = '0; s_ps[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        push_model("R1 reset", 1'b0);
        @(negedge clk);
        rst = 0;

        // R10: plain writes in supervisor
        step("R10 write svc", 0, M_SVC, 1, 32'hA000_0001, 1, 32'hA000_0002, 1, 32'hA000_0003);
        // R3 R4 R5: into IRQ, fresh bank reads zero
        go("R3 R4 R5 enter irq", M_IRQ);
        step("R10 write irq", 0, M_SVC, 1, 32'hB000_0001, 1, 32'hB000_0002, 1, 32'hB000_0003);
        go("R4 R5 back svc", M_SVC);
        go("R4 R5 back irq", M_IRQ);
        // R7: same mode, with and without writes
        go("R7 same mode", M_IRQ);
        step("R7 same mode with write", 1, M_IRQ, 1, 32'hB000_0011, 0, '0, 0, '0);
        // R8: illegal codes
        go("R8 code zero", 5'b00000);
        idle("R8 err clears");
        step("R8 bad code with write", 1, 5'b10100, 0, '0, 1, 32'hB000_0022, 0, '0);
        go("R8 bad code 11111", 5'b11111);
        // R9: write lands in outgoing bank
        step("R9 write with switch", 1, M_SVC, 1, 32'hC000_0001, 1, 32'hC000_0002, 1, 32'hC000_0003);
        go("R9 check irq shadow", M_IRQ);
        // R6: user has no status slot
        go("R6 enter user", M_USR);
        step("R6 ps write in user", 0, M_SVC, 1, 32'hD000_0001, 0, '0, 1, 32'hD000_0003);
        go("R6 leave user fiq", M_FIQ);
        go("R6 fiq to user", M_USR);
        go("R6 user to svc", M_SVC);
        go("R4 svc to user restores", M_USR);
        // R2: walk every mode
        go("R2 to abort", M_ABT);
        step("R10 write abt", 0, M_SVC, 1, 32'hE000_0001, 1, 32'hE000_0002, 1, 32'hE000_0003);
        go("R2 to undef", M_UND);
        step("R10 write und", 0, M_SVC, 1, 32'hF000_0001, 0, '0, 1, 32'hF000_0003);
        go("R2 to fiq", M_FIQ);
        go("R2 back abort", M_ABT);
        go("R2 back undef", M_UND);
        go("R2 to svc", M_SVC);
        idle("R1 drain");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        summary();
    end
endmodule